// File: doc/BRIEF.md
# Stop-State Wake-Up Controller

This block decides how a small microcontroller leaves its low-power stop state. Once software requests stop, the controller watches four kinds of wake source: a timeout pulse from the watchdog counter, level changes on input pins that are individually enabled for wake-up, an external reset pin, and an active-low debug pin. The watchdog and the enabled pins start a timed recovery sequence that ends with a one-cycle wake pulse to the CPU. The reset pin and the debug pin end the stop state with a full system reset pulse instead.

Pin changes are checked for a minimum stable width before they count as wake events. A change that lasts too short a time is discarded. While the part is stopped, the port input register is frozen. It takes the pin levels again only when recovery completes, so a pulse can wake the part and still never be recorded. A watchdog interrupt requested during stop is held back until the wake pulse. Three sticky status flags record why the part woke. Software clears them by writing ones.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A one-cycle `stop_req` while running makes `stopped` read 1 from the next cycle. While `stopped` is 1, `port_in` holds its value. While running, `port_in` follows `pin_in` with a latency of SYNC_STAGES+1 cycles.
- R2: On a pin whose `wake_en` bit is 1, a rising or falling change that stays for FILT_CYC consecutive cycles wakes the part. `cpu_wake` then pulses for exactly one cycle, SYNC_STAGES+FILT_CYC+RECOV_CYC clock edges after the edge at which the change is first sampled.
- R3: A pin change that lasts fewer than FILT_CYC cycles does not wake the part, and neither does any change on a pin whose `wake_en` bit is 0. In both cases `stopped` stays 1 and no `cpu_wake` appears.
- R4: `cpu_wake` is asserted only after the full recovery delay of RECOV_CYC cycles, only when leaving the stop state, and never for two cycles in a row. A pin wake sets `flag_stop`.
- R5: A `wdt_timeout` sampled while stopped starts recovery and sets both `flag_wdt` and `flag_stop`. `cpu_wake` follows RECOV_CYC+1 edges after the sampling edge.
- R6: `wdt_irq` pulses in the same cycle as `cpu_wake` only when the wake came from the watchdog, `wdt_irq_mode` was 1 at the timeout, and `irq_global_en` is 1 at the end of recovery. A pin wake never raises `wdt_irq`.
- R7: While stopped or recovering, `ext_rst_pin` high or `dbg_pin_n` low produces a one-cycle `sys_reset` with no `cpu_wake`, returns the block to running, clears `flag_stop` and sets `flag_ext`.
- R8: When a reset source and a recovery source are present in the same cycle, the reset source wins. `sys_reset` pulses and `flag_wdt` is not set.
- R9: At the end of recovery `port_in` captures the pin levels present at that moment. A wake pulse that has already ended is therefore not recorded.
- R10: When `flag_clr_we` is 1, each 1 in `flag_clr_mask` clears a flag: bit 0 clears `flag_stop`, bit 1 clears `flag_wdt`, and bit 2 clears `flag_ext`. A flag being set in the same cycle stays set.
- R11: After reset, `stopped`, `cpu_wake`, `sys_reset`, `wdt_irq`, `port_in` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running low-power clock |
| rst | input | 1 | synchronous active-high reset |
| stop_req | input | 1 | request to enter the stop state |
| wake_en | input | NUM_PINS | per-pin wake-source enable |
| pin_in | input | NUM_PINS | raw pin levels |
| ext_rst_pin | input | 1 | external reset pin, active high |
| dbg_pin_n | input | 1 | debug pin, active low |
| wdt_timeout | input | 1 | watchdog timeout pulse, synchronous |
| wdt_irq_mode | input | 1 | 1: watchdog set for interrupt |
| irq_global_en | input | 1 | global interrupt enable |
| flag_clr_we | input | 1 | write strobe for flag clearing |
| flag_clr_mask | input | 3 | ones clear flags: bit0 stop, bit1 wdt, bit2 ext |
| stopped | output | 1 | block is in stop or recovery |
| cpu_wake | output | 1 | one-cycle wake pulse to the CPU |
| sys_reset | output | 1 | one-cycle full system reset pulse |
| wdt_irq | output | 1 | delayed watchdog interrupt request |
| port_in | output | NUM_PINS | port input register |
| flag_stop | output | 1 | stop-recovery status flag |
| flag_wdt | output | 1 | watchdog status flag |
| flag_ext | output | 1 | external/debug reset status flag |

## Verification
If a pin filter holds a stale count or baseline, the error shows at the ports as a wake that comes a few edges early or late. It can also show as a glitch that wakes the part, visible within SYNC_STAGES+FILT_CYC edges of the pin change. A recovery counter that is off by one moves `cpu_wake` by one edge, so every wake latency is measured to the exact edge. A wrong wake cause or priority shows as a wrong flag, or as `sys_reset` and `cpu_wake` in the wrong place. A missed freeze shows as `port_in` moving while `stopped` is 1, or as a recorded pulse after recovery.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_RECOV = 2'd2
  } swk_state_e;

  localparam int FLAG_STOP = 0;
  localparam int FLAG_WDT  = 1;
  localparam int FLAG_EXT  = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/swk_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
module swk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swk_pin_filter.sv
// Per-pin change detector with a minimum stable width.
module swk_pin_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic en,
  input  logic lvl,
  output logic hit
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          base_q;
  logic [CW-1:0] cnt_q;
  logic          diff;

  assign diff = arm & en & (lvl != base_q);
  assign hit  = diff && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!arm) begin
      base_q <= lvl;
      cnt_q  <= '0;
    end else if (!diff) begin
      cnt_q  <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swk_recov_timer.sv
// Recovery delay counter: done after RECOV_CYC cycles of run.
module swk_recov_timer #(
  parameter int RECOV_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(RECOV_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= CW'(RECOV_CYC - 1);
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3,
  parameter int RECOV_CYC   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_req,
  input  logic [NUM_PINS-1:0] wake_en,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                ext_rst_pin,
  input  logic                dbg_pin_n,
  input  logic                wdt_timeout,
  input  logic                wdt_irq_mode,
  input  logic                irq_global_en,
  input  logic                flag_clr_we,
  input  logic [2:0]          flag_clr_mask,
  output logic                stopped,
  output logic                cpu_wake,
  output logic                sys_reset,
  output logic                wdt_irq,
  output logic [NUM_PINS-1:0] port_in,
  output logic                flag_stop,
  output logic                flag_wdt,
  output logic                flag_ext
);
  localparam int SW = NUM_PINS + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, {NUM_PINS{1'b0}}};

  swk_state_e          state_q;
  logic [SW-1:0]       sync_q;
  logic [NUM_PINS-1:0] s_pin;
  logic                s_ext;
  logic                s_dbg_n;
  logic [NUM_PINS-1:0] hit_vec;
  logic                any_hit;
  logic                arm_stop;
  logic                rst_src;
  logic                wake_go;
  logic                recov_run;
  logic                recov_done;
  logic                irq_pend_q;

  swk_sync #(
    .W      (SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({dbg_pin_n, ext_rst_pin, pin_in}),
    .q  (sync_q)
  );

  assign s_pin   = sync_q[NUM_PINS-1:0];
  assign s_ext   = sync_q[NUM_PINS];
  assign s_dbg_n = sync_q[NUM_PINS+1];

  assign arm_stop = (state_q == ST_STOP);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_filt
    swk_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk),
      .rst(rst),
      .arm(arm_stop),
      .en (wake_en[g]),
      .lvl(s_pin[g]),
      .hit(hit_vec[g])
    );
  end

  assign any_hit   = |hit_vec;
  assign rst_src   = s_ext | ~s_dbg_n;
  assign wake_go   = arm_stop && !rst_src && (wdt_timeout || any_hit);
  assign recov_run = (state_q == ST_RECOV) && !rst_src;

  swk_recov_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
    .clk (clk),
    .rst (rst),
    .load(wake_go),
    .run (recov_run),
    .done(recov_done)
  );

  assign stopped = (state_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      cpu_wake   <= 1'b0;
      sys_reset  <= 1'b0;
      wdt_irq    <= 1'b0;
      port_in    <= '0;
      flag_stop  <= 1'b0;
      flag_wdt   <= 1'b0;
      flag_ext   <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      cpu_wake  <= 1'b0;
      sys_reset <= 1'b0;
      wdt_irq   <= 1'b0;

      // software clears first; hardware sets below take precedence
      if (flag_clr_we) begin
        if (flag_clr_mask[FLAG_STOP]) flag_stop <= 1'b0;
        if (flag_clr_mask[FLAG_WDT])  flag_wdt  <= 1'b0;
        if (flag_clr_mask[FLAG_EXT])  flag_ext  <= 1'b0;
      end

      unique case (state_q)
        ST_RUN: begin
          port_in <= s_pin;
          if (stop_req) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (rst_src) begin
            state_q   <= ST_RUN;
            sys_reset <= 1'b1;
            flag_stop <= 1'b0;
            flag_ext  <= 1'b1;
          end else if (wdt_timeout) begin
            state_q    <= ST_RECOV;
            flag_stop  <= 1'b1;
            flag_wdt   <= 1'b1;
            irq_pend_q <= wdt_irq_mode;
          end else if (any_hit) begin
            state_q    <= ST_RECOV;
            flag_stop  <= 1'b1;
            irq_pend_q <= 1'b0;
          end
        end
        ST_RECOV: begin
          if (rst_src) begin
            state_q    <= ST_RUN;
            sys_reset  <= 1'b1;
            flag_stop  <= 1'b0;
            flag_ext   <= 1'b1;
            irq_pend_q <= 1'b0;
          end else if (recov_done) begin
            state_q    <= ST_RUN;
            cpu_wake   <= 1'b1;
            wdt_irq    <= irq_pend_q & irq_global_en;
            port_in    <= s_pin;
            irq_pend_q <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                stopped,
  input logic                cpu_wake,
  input logic                sys_reset,
  input logic                wdt_irq,
  input logic                irq_global_en,
  input logic [NUM_PINS-1:0] port_in,
  input logic                flag_stop,
  input logic                flag_ext
);
  p_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    (stopped && $past(stopped)) |-> $stable(port_in));

  p_no_wake_running_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(stopped) |-> !cpu_wake);

  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_wake |=> !cpu_wake);

  p_wake_exit_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_wake |-> (!stopped && $past(stopped)));

  p_irq_with_wake_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |-> (cpu_wake && $past(irq_global_en)));

  p_reset_flags_r7: assert property (@(posedge clk) disable iff (rst)
    sys_reset |-> (flag_ext && !flag_stop && !stopped));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(sys_reset && cpu_wake));
endmodule

bind stop_wake_ctrl swk_checker #(.NUM_PINS(NUM_PINS)) u_swk_checker (
  .clk          (clk),
  .rst          (rst),
  .stopped      (stopped),
  .cpu_wake     (cpu_wake),
  .sys_reset    (sys_reset),
  .wdt_irq      (wdt_irq),
  .irq_global_en(irq_global_en),
  .port_in      (port_in),
  .flag_stop    (flag_stop),
  .flag_ext     (flag_ext)
);

// File: tb/tb_stop_wake_ctrl.sv
`timescale 1ns/1ps
module tb_stop_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int SY = 2;
  localparam int FC = 3;
  localparam int RC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stop_req = 1'b0;
  logic [NP-1:0] wake_en = '1;
  logic [NP-1:0] pin_in = '0;
  logic          ext_rst_pin = 1'b0;
  logic          dbg_pin_n = 1'b1;
  logic          wdt_timeout = 1'b0;
  logic          wdt_irq_mode = 1'b0;
  logic          irq_global_en = 1'b0;
  logic          flag_clr_we = 1'b0;
  logic [2:0]    flag_clr_mask = '0;
  logic          stopped, cpu_wake, sys_reset, wdt_irq;
  logic [NP-1:0] port_in;
  logic          flag_stop, flag_wdt, flag_ext;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit finished = 0;

  stop_wake_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(SY), .FILT_CYC(FC), .RECOV_CYC(RC)) dut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_en(wake_en), .pin_in(pin_in),
    .ext_rst_pin(ext_rst_pin), .dbg_pin_n(dbg_pin_n), .wdt_timeout(wdt_timeout),
    .wdt_irq_mode(wdt_irq_mode), .irq_global_en(irq_global_en),
    .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .stopped(stopped), .cpu_wake(cpu_wake), .sys_reset(sys_reset), .wdt_irq(wdt_irq),
    .port_in(port_in), .flag_stop(flag_stop), .flag_wdt(flag_wdt), .flag_ext(flag_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic go_stop();
    settle();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(stopped == 1'b1, "R1 stop entry", int'(stopped), 1);
  endtask

  // waits for cpu_wake or sys_reset, counting edges from the last negedge
  task automatic wait_event(input int limit, output int n, output bit woke,
                            output bit rsted, output bit irq);
    n = 0; woke = 0; rsted = 0; irq = 0;
    for (int k = 0; k < limit; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (cpu_wake)  begin woke = 1; irq = wdt_irq; break; end
      if (sys_reset) begin rsted = 1; break; end
    end
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr_we = 1'b1;
    flag_clr_mask = m;
    @(negedge clk);
    flag_clr_we = 1'b0;
    flag_clr_mask = '0;
  endtask

  task automatic wdt_pulse();
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
  endtask

  initial begin
    int n;
    bit woke, rsted, irq;
    logic [NP-1:0] lvl;
    lvl = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(stopped == 0 && cpu_wake == 0 && sys_reset == 0 && wdt_irq == 0,
        "R11 outputs after reset", int'({stopped, cpu_wake, sys_reset, wdt_irq}), 0);
    chk(port_in == '0 && {flag_stop, flag_wdt, flag_ext} == 3'b000,
        "R11 port and flags after reset", int'({port_in, flag_stop, flag_wdt, flag_ext}), 0);

    // R1 running follow
    pin_in = 4'b0101;
    settle();
    chk(port_in == 4'b0101, "R1 port follows pins when running", int'(port_in), 5);
    pin_in = '0;
    settle();

    // R2/R9 every pin, both directions, exact latency
    wdt_irq_mode = 1'b1;
    irq_global_en = 1'b1;
    for (int p = 0; p < NP; p++) begin
      for (int d = 0; d < 2; d++) begin
        logic [NP-1:0] old_lvl;
        old_lvl = lvl;
        go_stop();
        lvl[p] = ~lvl[p];
        pin_in = lvl;
        n = 0; woke = 0;
        for (int k = 0; k < 40; k++) begin
          @(posedge clk);
          n++;
          @(negedge clk);
          if (n == 6)
            chk(port_in == old_lvl, "R1 port frozen while stopped", int'(port_in), int'(old_lvl));
          if (cpu_wake) begin woke = 1; irq = wdt_irq; break; end
        end
        chk(woke && n == SY + FC + RC, "R2 pin wake latency", n, SY + FC + RC);
        chk(port_in == lvl, "R9 level captured at recovery end", int'(port_in), int'(lvl));
        chk(flag_stop == 1'b1, "R4 stop flag after pin wake", int'(flag_stop), 1);
        chk(irq == 1'b0, "R6 no irq on pin wake", int'(irq), 0);
        clear_flags(3'b111);
      end
    end

    // R3/R9 pulse width sweep on pin 1 (currently 0)
    for (int w = 1; w <= FC + 1; w++) begin
      go_stop();
      pin_in[1] = 1'b1;
      repeat (w) @(negedge clk);
      pin_in[1] = 1'b0;
      wait_event(30, n, woke, rsted, irq);
      if (w < FC) begin
        chk(!woke && stopped, "R3 short pulse ignored", int'(woke), 0);
        wdt_pulse();
        wait_event(30, n, woke, rsted, irq);
      end else begin
        chk(woke, "R2 pulse at minimum width wakes", int'(woke), 1);
      end
      chk(port_in[1] == 1'b0, "R9 ended pulse not recorded", int'(port_in[1]), 0);
      clear_flags(3'b111);
    end

    // R3 disabled pin
    wake_en = 4'b1110;
    go_stop();
    lvl[0] = ~lvl[0];
    pin_in = lvl;
    wait_event(25, n, woke, rsted, irq);
    chk(!woke && stopped, "R3 disabled pin ignored", int'(woke), 0);
    wdt_pulse();
    wait_event(30, n, woke, rsted, irq);
    chk(port_in == lvl, "R9 disabled pin level captured at end", int'(port_in), int'(lvl));
    wake_en = '1;
    clear_flags(3'b111);

    // R5/R6 watchdog wake, all irq configurations
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        wdt_irq_mode = m[0];
        irq_global_en = e[0];
        go_stop();
        wdt_pulse();
        wait_event(30, n, woke, rsted, irq);
        chk(woke && n == RC, "R5 watchdog wake latency", n, RC);
        chk(flag_wdt && flag_stop, "R5 watchdog flags", int'({flag_wdt, flag_stop}), 3);
        chk(irq == (m[0] & e[0]), "R6 irq gating", int'(irq), m & e);
        clear_flags(3'b111);
      end
    end

    // R7 external reset while stopped
    go_stop();
    ext_rst_pin = 1'b1;
    wait_event(20, n, woke, rsted, irq);
    chk(rsted && !woke, "R7 ext pin gives system reset", int'(rsted), 1);
    chk(flag_ext && !flag_stop && !stopped, "R7 flags after ext reset",
        int'({flag_ext, flag_stop, stopped}), 4);
    ext_rst_pin = 1'b0;
    clear_flags(3'b111);

    // R7 debug low during recovery
    go_stop();
    wdt_pulse();
    @(negedge clk);
    dbg_pin_n = 1'b0;
    wait_event(20, n, woke, rsted, irq);
    chk(rsted && !woke, "R7 debug pin aborts recovery", int'(rsted), 1);
    chk(flag_ext && !flag_stop, "R7 flags after debug reset", int'({flag_ext, flag_stop}), 2);
    dbg_pin_n = 1'b1;
    settle();
    chk(!stopped && !cpu_wake, "R7 running after reset, no late wake", int'({stopped, cpu_wake}), 0);
    clear_flags(3'b111);

    // R8 same-cycle reset and watchdog
    go_stop();
    ext_rst_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    chk(sys_reset && !cpu_wake, "R8 reset wins", int'(sys_reset), 1);
    chk(!flag_wdt && flag_ext, "R8 watchdog flag not set", int'(flag_wdt), 0);
    ext_rst_pin = 1'b0;
    settle();

    // R10 write-one-to-clear
    go_stop();
    wdt_pulse();
    wait_event(30, n, woke, rsted, irq);
    chk({flag_ext, flag_wdt, flag_stop} == 3'b111, "R10 all flags set", int'({flag_ext, flag_wdt, flag_stop}), 7);
    clear_flags(3'b010);
    chk({flag_ext, flag_wdt, flag_stop} == 3'b101, "R10 clear bit1 only", int'({flag_ext, flag_wdt, flag_stop}), 5);
    clear_flags(3'b101);
    chk({flag_ext, flag_wdt, flag_stop} == 3'b000, "R10 clear bits 0 and 2", int'({flag_ext, flag_wdt, flag_stop}), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule